// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This block sits inside an MMU, after the point where descriptor bits have been fetched or read from a translation cache. It turns the type bits of a page-table descriptor, together with the descriptor's shareable bit and the security world of the request, into the final memory attributes. These are the memory type (strongly ordered, device or normal), the inner and outer cacheability, and the shareability. One copy of the logic serves instruction, data and DMA requesters alike.

The remap is set by two 32-bit registers. The primary register chooses the memory type per descriptor index and also holds the shareable remap bits. The normal register chooses the inner and outer cache policies. Each register is banked, with one copy for the secure world and one for the non-secure world. Software loads them through a simple write port and reads them back through a combinational read port. The lookup is purely combinational on the stored registers, so a register write changes the result of every lookup from the next cycle onward, and no cached translation needs to be flushed.

Top module: `mem_attr_remap`

## Requirements
- R1: The lookup index is n = {lk_tex0, lk_c, lk_b}, with lk_tex0 as the most significant bit. The raw type is bits [2n+1:2n] of the primary register. The reported mem_type is 00 (strongly ordered) for raw 00, 01 (device) for raw 01, and 10 (normal) for raw 10 or 11. mem_type never reads 11.
- R2: When mem_type is normal, inner_attr equals bits [2n+1:2n] of the normal register and outer_attr equals bits [2n+17:2n+16] of it. This holds whatever type the descriptor index originally implied.
- R3: When mem_type is strongly ordered or device, inner_attr and outer_attr are both 00 (non-cacheable).
- R4: When mem_type is strongly ordered, shareable is 1 regardless of lk_s.
- R5: When mem_type is device, shareable equals primary-register bit 16 if lk_s is 0 and bit 17 if lk_s is 1. When mem_type is normal, shareable equals bit 18 if lk_s is 0 and bit 19 if lk_s is 1.
- R6: A lookup uses the secure copies of both registers when lk_secure is 1 and the non-secure copies when it is 0. A write with wr_sel = 0 (primary) or 1 (normal) changes only the copy of the world given by wr_secure. The other three registers keep their values.
- R7: A write takes effect at the clock edge where wr_en is high. A lookup in the same cycle as the write still sees the old value, and a lookup in the following cycle sees the new one.
- R8: After reset all four registers read as zero. rd_data shows the register chosen by rd_sel (0 primary, 1 normal) and rd_secure, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register written: 0 primary, 1 normal |
| wr_secure | input | 1 | World of the writer: 1 secure |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Register read: 0 primary, 1 normal |
| rd_secure | input | 1 | World of the read: 1 secure |
| rd_data | output | 32 | Read data |
| lk_tex0 | input | 1 | Lowest type-extension bit of the descriptor |
| lk_c | input | 1 | Descriptor C bit |
| lk_b | input | 1 | Descriptor B bit |
| lk_s | input | 1 | Descriptor shareable bit |
| lk_secure | input | 1 | Security world of the request |
| mem_type | output | 2 | 00 strongly ordered, 01 device, 10 normal |
| inner_attr | output | 2 | Inner cache policy: 00 NC, 01 WB-WA, 10 WT, 11 WB-no-WA |
| outer_attr | output | 2 | Outer cache policy, same encoding |
| shareable | output | 1 | Final shareability |

## Verification
A register write and a lookup can fall in the same cycle, and they can use the same or the other security world. The bench raises wr_en with a new primary value while it holds a lookup on the matching world. It checks that the outputs before the edge still follow the old contents and that the outputs after the edge follow the new ones. It then repeats the collision with a write to the other world and checks that the lookup does not change at all.

// File: rtl/mem_attr_remap_pkg.sv
// Package: shared types for the memory attribute remap unit.
// Assumes a 2-bit memory type code and 2-bit cache policy codes.
package mem_attr_remap_pkg;
    typedef enum logic [1:0] {
        MT_STRONG = 2'b00,
        MT_DEVICE = 2'b01,
        MT_NORMAL = 2'b10
    } mem_type_e;

    typedef struct packed {
        mem_type_e  mtype;
        logic [1:0] inner;
        logic [1:0] outer;
        logic       shared;
    } attr_t;
endpackage

// File: rtl/mar_regbank.sv
// Module: banked storage for the remap registers.
// One register per (world, kind) slot; slot index = {world, kind}.
// Assumes one write per cycle; reset is synchronous active-low.
module mar_regbank #(
    parameter int REG_W   = 32,
    parameter int N_WORLD = 2,
    parameter int N_KIND  = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [$clog2(N_WORLD*N_KIND)-1:0]       wr_slot,
    input  logic [REG_W-1:0]                        wr_data,
    output logic [N_WORLD*N_KIND-1:0][REG_W-1:0]    regs_o
);
    localparam int N_SLOT = N_WORLD * N_KIND;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        logic [REG_W-1:0] q;
        // Load this slot when the write targets it; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_slot == g[$clog2(N_SLOT)-1:0])) begin
                q <= wr_data;
            end
        end
        assign regs_o[g] = q;
    end
endmodule

// File: rtl/mar_lookup.sv
// Module: combinational two-level attribute remap.
// Level one picks the memory type from the primary register by index;
// level two picks cache policies from the normal register when the type
// is normal. Shareability is remapped by type and the descriptor S bit.
// Assumes the primary register covers 8 two-bit type fields plus 4 share bits.
module mar_lookup
    import mem_attr_remap_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int REG_W = 32
) (
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 s_i,
    input  logic [2*(1<<IDX_W)+3:0] prim_i,
    input  logic [REG_W-1:0]     norm_i,
    output attr_t                attr_o
);
    localparam int N_ENT     = 1 << IDX_W;
    localparam int OUTER_OFS = 2 * N_ENT;
    localparam int SHARE_OFS = 2 * N_ENT;
    localparam int BIT_W     = $clog2(REG_W);

    logic [BIT_W-1:0] fld_lo;
    logic [1:0]       raw_type;

    // Bit offset of the entry field for this index.
    assign fld_lo   = BIT_W'({idx_i, 1'b0});
    assign raw_type = prim_i[fld_lo +: 2];

    // Decode type, select cache policies and remap shareability.
    always_comb begin
        attr_o = '0;
        unique case (raw_type)
            2'b00:   attr_o.mtype = MT_STRONG;
            2'b01:   attr_o.mtype = MT_DEVICE;
            default: attr_o.mtype = MT_NORMAL;
        endcase
        unique case (attr_o.mtype)
            MT_STRONG: attr_o.shared = 1'b1;
            MT_DEVICE: attr_o.shared = prim_i[SHARE_OFS + {1'b0, s_i}];
            default: begin
                attr_o.shared = prim_i[SHARE_OFS + 2 + {1'b0, s_i}];
                attr_o.inner  = norm_i[fld_lo +: 2];
                attr_o.outer  = norm_i[BIT_W'(OUTER_OFS) + fld_lo +: 2];
            end
        endcase
    end
endmodule

// File: rtl/mem_attr_remap.sv
// Module: top of the memory attribute remap unit.
// Holds banked remap registers and applies them to each lookup combinationally,
// so writes act on the lookup of the next cycle. Assumes REG_W = 32, IDX_W = 3.
module mem_attr_remap
    import mem_attr_remap_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic             wr_secure,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    input  logic             rd_secure,
    output logic [REG_W-1:0] rd_data,
    input  logic             lk_tex0,
    input  logic             lk_c,
    input  logic             lk_b,
    input  logic             lk_s,
    input  logic             lk_secure,
    output logic [1:0]       mem_type,
    output logic [1:0]       inner_attr,
    output logic [1:0]       outer_attr,
    output logic             shareable
);
    localparam int N_SLOT = 4;
    localparam int PRIM_W = 2 * (1 << IDX_W) + 4;

    logic [N_SLOT-1:0][REG_W-1:0] regs_w;
    logic [REG_W-1:0]             prim_w;
    logic [REG_W-1:0]             norm_w;
    attr_t                        attr_w;

    mar_regbank #(.REG_W(REG_W), .N_WORLD(2), .N_KIND(2)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot ({wr_secure, wr_sel}),
        .wr_data (wr_data),
        .regs_o  (regs_w)
    );

    // Pick the register pair of the requesting world and the read target.
    always_comb begin
        prim_w  = regs_w[{lk_secure, 1'b0}];
        norm_w  = regs_w[{lk_secure, 1'b1}];
        rd_data = regs_w[{rd_secure, rd_sel}];
    end

    mar_lookup #(.IDX_W(IDX_W), .REG_W(REG_W)) look_i (
        .idx_i  ({lk_tex0, lk_c, lk_b}),
        .s_i    (lk_s),
        .prim_i (prim_w[PRIM_W-1:0]),
        .norm_i (norm_w),
        .attr_o (attr_w)
    );

    // Drive the attribute outputs from the lookup result.
    always_comb begin
        mem_type   = attr_w.mtype;
        inner_attr = attr_w.inner;
        outer_attr = attr_w.outer;
        shareable  = attr_w.shared;
    end
endmodule

// File: rtl/mem_attr_remap_chk.sv
// Checker: temporal properties of the remap unit, bound to the top.
module mem_attr_remap_chk #(
    parameter int REG_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   wr_sel,
    input logic                   wr_secure,
    input logic [REG_W-1:0]       wr_data,
    input logic [3:0][REG_W-1:0]  regs,
    input logic [1:0]             mem_type,
    input logic [1:0]             inner_attr,
    input logic [1:0]             outer_attr,
    input logic                   shareable
);
    logic [1:0] widx;
    assign widx = {wr_secure, wr_sel};

    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_type != 2'b11);                                            // R1
    AST_NONNORM_NC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_type != 2'b10) |-> (inner_attr == 2'b00 && outer_attr == 2'b00)); // R3
    AST_STRONG_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_type == 2'b00) |-> shareable);                            // R4
    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(widx)] == $past(wr_data)));              // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));                                     // R6
endmodule

bind mem_attr_remap mem_attr_remap_chk #(.REG_W(REG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_secure  (wr_secure),
    .wr_data    (wr_data),
    .regs       (regs_w),
    .mem_type   (mem_type),
    .inner_attr (inner_attr),
    .outer_attr (outer_attr),
    .shareable  (shareable)
);

// File: tb/mem_attr_remap_tb.sv
// Directed bench for the memory attribute remap unit.
module mem_attr_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, wr_secure = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0, rd_secure = 1'b0;
    logic [31:0] rd_data;
    logic        lk_tex0 = 1'b0, lk_c = 1'b0, lk_b = 1'b0, lk_s = 1'b0, lk_secure = 1'b0;
    logic [1:0]  mem_type, inner_attr, outer_attr;
    logic        shareable;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] shadow [4];   // bench copy: index {secure, kind}

    always #5 clk = ~clk;

    mem_attr_remap dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_secure(wr_secure), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_secure(rd_secure), .rd_data(rd_data), .lk_tex0(lk_tex0),
        .lk_c(lk_c), .lk_b(lk_b), .lk_s(lk_s), .lk_secure(lk_secure),
        .mem_type(mem_type), .inner_attr(inner_attr),
        .outer_attr(outer_attr), .shareable(shareable)
    );

    // Expected {type, inner, outer, share} from the requirements.
    function automatic logic [6:0] model(input logic [31:0] p, input logic [31:0] m,
                                         input int n, input logic s);
        logic [1:0] t, in_a, out_a;
        logic       sh;
        t = p[2*n +: 2];
        if (t == 2'b11) t = 2'b10;
        in_a = 2'b00; out_a = 2'b00;
        if (t == 2'b00) sh = 1'b1;
        else if (t == 2'b01) sh = p[16 + int'(s)];
        else begin
            sh = p[18 + int'(s)];
            in_a = m[2*n +: 2];
            out_a = m[2*n + 16 +: 2];
        end
        return {t, in_a, out_a, sh};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sec, input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_secure = sec; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[{sec, sel}] = d;
    endtask

    task automatic look(input string req, input logic sec, input int n, input logic s);
        logic [6:0] e;
        lk_secure = sec; lk_s = s;
        {lk_tex0, lk_c, lk_b} = 3'(n);
        #1;
        e = model(shadow[{sec, 1'b0}], shadow[{sec, 1'b1}], n, s);
        check(req, {25'd0, mem_type, inner_attr, outer_attr, shareable}, {25'd0, e});
    endtask

    // R8: reset clears all registers; R3/R4 on zeroed registers.
    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            rd_secure = i[1]; rd_sel = i[0]; #1;
            check("R8 reset readback", rd_data, 32'h0);
        end
        look("R4 R3 strong after reset", 1'b0, 5, 1'b0);
    endtask

    // R1 R2 R3 R4 R5: every index and S value on the non-secure bank.
    task automatic t_decode();
        logic [31:0] p;
        p = 32'h0006_0000;  // bit17 and bit18 set
        p[15:0] = {2'b11, 2'b00, 2'b10, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
        do_write(1'b0, 1'b0, p);
        do_write(1'b0, 1'b1, 32'hA5C3_96E1);
        for (int n = 0; n < 8; n++)
            for (int s = 0; s < 2; s++)
                look("R1 R2 R3 R4 R5 decode", 1'b0, n, s[0]);
        p[19:16] = 4'b1001;
        do_write(1'b0, 1'b0, p);
        for (int n = 0; n < 8; n++)
            for (int s = 0; s < 2; s++)
                look("R5 share bits swapped", 1'b0, n, s[0]);
    endtask

    // R6: secure bank independent of the non-secure bank.
    task automatic t_banking();
        do_write(1'b1, 1'b0, 32'h000A_AAAA);  // all normal
        do_write(1'b1, 1'b1, 32'h1234_FEDC);
        for (int n = 0; n < 8; n++) begin
            look("R6 secure bank", 1'b1, n, 1'b1);
            look("R6 nonsecure bank", 1'b0, n, 1'b0);
        end
        for (int i = 0; i < 4; i++) begin
            rd_secure = i[1]; rd_sel = i[0]; #1;
            check("R6 R8 readback", rd_data, shadow[i]);
        end
    endtask

    // R7: write and lookup in the same cycle; also a write to the other world.
    task automatic t_collide();
        logic [6:0] e_old, e_new;
        logic [31:0] p_new;
        p_new = 32'h000F_FFFF;
        @(negedge clk);
        lk_secure = 1'b0; lk_s = 1'b0; {lk_tex0, lk_c, lk_b} = 3'd2;
        wr_en = 1'b1; wr_secure = 1'b0; wr_sel = 1'b0; wr_data = p_new;
        #1;
        e_old = model(shadow[0], shadow[1], 2, 1'b0);
        check("R7 same cycle sees old", {25'd0, mem_type, inner_attr, outer_attr, shareable}, {25'd0, e_old});
        @(negedge clk);
        wr_en = 1'b0; shadow[0] = p_new;
        #1;
        e_new = model(shadow[0], shadow[1], 2, 1'b0);
        check("R7 next cycle sees new", {25'd0, mem_type, inner_attr, outer_attr, shareable}, {25'd0, e_new});
        @(negedge clk);
        wr_en = 1'b1; wr_secure = 1'b1; wr_sel = 1'b0; wr_data = 32'h0;
        @(negedge clk);
        wr_en = 1'b0; shadow[2] = 32'h0;
        #1;
        check("R6 other world write no effect", {25'd0, mem_type, inner_attr, outer_attr, shareable}, {25'd0, e_new});
        look("R6 secure sees its write", 1'b1, 2, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_banking();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule